// File: doc/BRIEF.md
# Reset Cause Capture and Write-Once System Options

This block keeps two byte-wide registers that system software reads early after every reset. The first is a read-only cause register. It records which reset sources were active when the chip entered reset. The second is a system options register that can be written only once. It carries the watchdog enable, the watchdog long-timeout select, the stop-mode enable, a spare bit, the debug-pin enable and the reset-pin enable.

The seven reset-source indications are latched on every clock while the synchronous reset `rst_n` is held low. The cause byte is encoded from the copy latched in the last held cycle, and it is written on the first clock edge after release. A CPU register port (select, write strobe, address, write data, combinational read data) reaches both registers. A write of any value to the cause address leaves the cause byte unchanged and produces a one-cycle watchdog-clear pulse.

A small state machine governs the options register. Its states are:
- `S_HOLD`: reset is held. Options are forced to their reset pattern.
- `S_OPEN`: reset has been released. The first options write is accepted.
- `S_LOCKED`: every later options write is ignored.

Its transitions are:
- `HOLD->OPEN`: the first edge with reset released. This is also the cause-capture edge.
- `OPEN->LOCKED`: an options write.
- any state `->HOLD`: reset asserted.

Top module: `rst_opt_ctl`

## Requirements
- R1: Cause byte layout: bit7 power-on, bit6 external pin, bit5 watchdog, bit4 illegal opcode, bit3 illegal address, bit1 low-voltage. A reset with power-on active (and debug-forced inactive) yields 0x82.
- R2: A reset with low-voltage active, and with power-on and debug-forced inactive, yields 0x02, whatever the other sources are.
- R3: Any other reset sets bit6, bit5, bit4 and bit3 to the pin, watchdog, illegal-opcode and illegal-address inputs respectively. Bits 7, 2, 1 and 0 read 0.
- R4: A reset with debug-forced active yields 0x00, whatever the other sources are.
- R5: The sources are sampled on the last clock edge with reset held. The cause byte is loaded on the first edge after release, and later source changes do not affect it.
- R6: A write of any value to address 0 leaves the cause byte unchanged. It drives `wdog_clr` high for exactly the cycle after the write edge. Writes to other addresses never pulse it.
- R7: After reset, options bits 7, 6, 4 and 1 read 1, bits 5, 3 and 2 read 0, and bits 3 and 2 always read 0.
- R8: Options bit0 (reset-pin enable) is cleared by a reset with power-on active and is otherwise kept across reset.
- R9: The first write to address 1 after reset stores `wdata` with bits 3 and 2 forced to 0. Every later write is ignored until the next reset.
- R10: Every reset, of whatever type, reopens the options register for one new write.
- R11: `rdata` shows the cause byte at address 0 and the options at address 1 when `sel` is high. It reads 0 for any other address or when `sel` is low. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_por | input | 1 | Power-on reset source |
| src_lvd | input | 1 | Low-voltage reset source |
| src_pin | input | 1 | External pin reset source |
| src_wdog | input | 1 | Watchdog timeout reset source |
| src_ilop | input | 1 | Illegal opcode reset source |
| src_ilad | input | 1 | Illegal address reset source |
| src_dbg | input | 1 | Debug-forced reset source |
| sel | input | 1 | Register access select |
| wr | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| wdog_clr | output | 1 | One-cycle watchdog service pulse |

## Verification
The bench drives combined source patterns against the precedence debug > power-on > low-voltage > individual flags.
- A wrong precedence would report 0x82 or 0x02 where 0x00 is due, or would leak pin bits past a low-voltage cause.

Sources are changed during and after the reset hold.
- A design sampling too early or too late would record the wrong cause.

The reset-pin enable bit is toggled by accepted writes and then checked across both power-on and non-power-on resets.
- A design that resets it on every reset, or never, fails those checks.

A second options write is always attempted.
- A lock that is missing, or not reopened by reset, shows up in the read-back.

Cause-address writes are checked for an unchanged read-back, a pulse of exactly one cycle, and no locking side effect.

// File: rtl/rso_pkg.sv
package rso_pkg;

    typedef enum logic [1:0] {
        S_HOLD   = 2'd0,
        S_OPEN   = 2'd1,
        S_LOCKED = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic dbg;
        logic por;
        logic lvd;
        logic pin;
        logic wdog;
        logic ilop;
        logic ilad;
    } rst_src_t;

    localparam int unsigned BYTE_W = 8;

    // cause byte bit positions
    localparam int unsigned CB_POR  = 7;
    localparam int unsigned CB_PIN  = 6;
    localparam int unsigned CB_WDOG = 5;
    localparam int unsigned CB_ILOP = 4;
    localparam int unsigned CB_ILAD = 3;
    localparam int unsigned CB_LVD  = 1;

    // options: reset pattern for bits 7..1 and writable mask
    localparam logic [BYTE_W-1:0] OPT_RST   = 8'hD2;
    localparam logic [BYTE_W-1:0] OPT_WMASK = 8'hF3;

    function automatic logic [BYTE_W-1:0] cause_encode(input rst_src_t s);
        logic [BYTE_W-1:0] v;
        v = '0;
        if (s.dbg) begin
            v = '0;
        end else if (s.por) begin
            v[CB_POR] = 1'b1;
            v[CB_LVD] = 1'b1;
        end else if (s.lvd) begin
            v[CB_LVD] = 1'b1;
        end else begin
            v[CB_PIN]  = s.pin;
            v[CB_WDOG] = s.wdog;
            v[CB_ILOP] = s.ilop;
            v[CB_ILAD] = s.ilad;
        end
        return v;
    endfunction

endpackage

// File: rtl/rso_src_latch.sv
module rso_src_latch
    import rso_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  rst_src_t src_in,
    output rst_src_t src_q
);
    // follows the sources while reset is held, frozen once released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= src_in;
        end
    end
endmodule

// File: rtl/rso_cause_reg.sv
module rso_cause_reg
    import rso_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  rst_src_t          src_q,
    output logic [BYTE_W-1:0] cause
);
    always_ff @(posedge clk) begin
        if (capture) begin
            cause <= cause_encode(src_q);
        end
    end

    AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(cause)) else $error("cause changed outside capture"); // R6

    AST_DBG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && src_q.dbg) |=> (cause == '0)) else $error("debug reset not clear"); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (!cause[2] && !cause[0])) else $error("reserved cause bits set"); // R3

    AST_POR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !src_q.dbg && src_q.por) |=> (cause[CB_POR] && cause[CB_LVD])) else $error("por pair"); // R1
endmodule

// File: rtl/rso_opt_fsm.sv
module rso_opt_fsm
    import rso_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_in,
    input  logic              opt_wr,
    input  logic [BYTE_W-1:0] opt_wdata,
    output logic [BYTE_W-1:0] opt_q,
    output logic              capture
);
    lock_state_e state, state_nx;
    logic        wr_ok;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_HOLD:   state_nx = S_OPEN;
            S_OPEN:   if (opt_wr) state_nx = S_LOCKED;
            S_LOCKED: state_nx = S_LOCKED;
            default:  state_nx = S_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        capture = 1'b0;
        wr_ok   = 1'b0;
        unique case (state)
            S_HOLD:   capture = rst_n;
            S_OPEN:   wr_ok   = 1'b1;
            S_LOCKED: wr_ok   = 1'b0;
            default:  capture = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opt_q[BYTE_W-1:1] <= OPT_RST[BYTE_W-1:1];
            if (por_in) opt_q[0] <= 1'b0;
        end else if (wr_ok && opt_wr) begin
            opt_q <= opt_wdata & OPT_WMASK;
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOCKED) |=> (state == S_LOCKED)) else $error("lock lost"); // R9

    AST_OPT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOCKED) |=> $stable(opt_q)) else $error("locked options changed"); // R9

    AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (state == S_OPEN)) else $error("not reopened"); // R10

    AST_OPT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (opt_q[3:2] == 2'b00)) else $error("options reserved bits"); // R7
endmodule

// File: rtl/rst_opt_ctl.sv
module rst_opt_ctl
    import rso_pkg::*;
#(
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned CAUSE_ADR = 0,
    parameter int unsigned OPT_ADR   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_por,
    input  logic              src_lvd,
    input  logic              src_pin,
    input  logic              src_wdog,
    input  logic              src_ilop,
    input  logic              src_ilad,
    input  logic              src_dbg,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              wdog_clr
);
    localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(CAUSE_ADR);
    localparam logic [ADDR_W-1:0] A_OPT   = ADDR_W'(OPT_ADR);

    rst_src_t          src_in, src_q;
    logic              capture;
    logic [BYTE_W-1:0] cause, opt_q;
    logic              cause_wr, opt_wr;

    assign src_in = '{dbg: src_dbg, por: src_por, lvd: src_lvd, pin: src_pin,
                      wdog: src_wdog, ilop: src_ilop, ilad: src_ilad};

    assign cause_wr = sel && wr && (addr == A_CAUSE);
    assign opt_wr   = sel && wr && (addr == A_OPT);

    rso_src_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_in),
        .src_q  (src_q)
    );

    rso_cause_reg u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .src_q   (src_q),
        .cause   (cause)
    );

    rso_opt_fsm u_opt (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_in    (src_por),
        .opt_wr    (opt_wr),
        .opt_wdata (wdata),
        .opt_q     (opt_q),
        .capture   (capture)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) wdog_clr <= 1'b0;
        else        wdog_clr <= cause_wr;
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            if (addr == A_CAUSE)    rdata = cause;
            else if (addr == A_OPT) rdata = opt_q;
        end
    end

    AST_WDOG_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_clr |-> $past(cause_wr)) else $error("stray watchdog clear"); // R6

    AST_WDOG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cause_wr |=> wdog_clr) else $error("missing watchdog clear"); // R6
endmodule

// File: tb/rst_opt_ctl_test.sv
`timescale 1ns/1ps
module rst_opt_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] src;          // {dbg,por,lvd,pin,wdog,ilop,ilad}
    logic       sel, wr;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic       wdog_clr;
    int         checks = 0;
    int         fails  = 0;
    logic       rstpe_exp;

    always #2.5 clk = ~clk;

    rst_opt_ctl uut (
        .clk(clk), .rst_n(rst_n),
        .src_por(src[5]), .src_lvd(src[4]), .src_pin(src[3]), .src_wdog(src[2]),
        .src_ilop(src[1]), .src_ilad(src[0]), .src_dbg(src[6]),
        .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
        .rdata(rdata), .wdog_clr(wdog_clr)
    );

    // {sources, expected cause}
    localparam logic [14:0] VEC [13] = '{
        {7'b0100000, 8'h82}, {7'b0110000, 8'h82}, {7'b0010000, 8'h02},
        {7'b0001000, 8'h40}, {7'b0000100, 8'h20}, {7'b0000010, 8'h10},
        {7'b0000001, 8'h08}, {7'b0001010, 8'h50}, {7'b0001111, 8'h78},
        {7'b0011000, 8'h02}, {7'b1001000, 8'h00}, {7'b1100000, 8'h00},
        {7'b0000000, 8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [6:0] s);
        @(negedge clk);
        rst_n = 1'b0; src = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; src = 7'b0;
        @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #0.5 d = rdata;
        sel = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; src = 7'b0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        rstpe_exp = 1'b0;
        for (int i = 0; i < 13; i++) begin
            logic [7:0] w;
            do_reset(VEC[i][14:8]);
            if (VEC[i][13]) rstpe_exp = 1'b0;
            bus_rd(2'd0, rd); chk("R1/R2/R3/R4 cause", rd, VEC[i][7:0]);
            bus_rd(2'd1, rd); chk("R7/R8 options after reset", rd, 8'hD2 | {7'b0, rstpe_exp});
            chk("R6 no pulse after reset", {7'b0, wdog_clr}, 8'h00);
            w = (i % 2 == 1) ? 8'hAD : 8'h5E;
            bus_wr(2'd1, w);
            chk("R6 options write no pulse", {7'b0, wdog_clr}, 8'h00);
            bus_rd(2'd1, rd); chk("R9 first write", rd, w & 8'hF3);
            rstpe_exp = w[0];
            bus_wr(2'd1, 8'h0C);
            bus_rd(2'd1, rd); chk("R9 second write ignored", rd, w & 8'hF3);
        end

        // R5: sources change while held; last held cycle wins
        @(negedge clk);
        rst_n = 1'b0; src = 7'b0001000;
        repeat (3) @(negedge clk);
        src = 7'b0000100;
        @(negedge clk);
        rst_n = 1'b1; src = 7'b0000001;
        @(negedge clk);
        bus_rd(2'd0, rd); chk("R5 last-cycle sample", rd, 8'h20);
        repeat (2) @(negedge clk);
        bus_rd(2'd0, rd); chk("R5 later sources ignored", rd, 8'h20);
        bus_rd(2'd1, rd); chk("R8 kept on non-por reset", rd, 8'hD2 | {7'b0, rstpe_exp});

        // R6: cause write
        bus_wr(2'd0, 8'hFF);
        chk("R6 pulse", {7'b0, wdog_clr}, 8'h01);
        bus_rd(2'd0, rd); chk("R6 cause unchanged", rd, 8'h20);
        @(negedge clk);
        chk("R6 pulse one cycle", {7'b0, wdog_clr}, 8'h00);

        // R11: unmapped address and sel low
        bus_wr(2'd2, 8'h00);
        chk("R11 unmapped write no pulse", {7'b0, wdog_clr}, 8'h00);
        bus_rd(2'd2, rd); chk("R11 unmapped read", rd, 8'h00);
        addr = 2'd0; #0.5 chk("R11 sel low", rdata, 8'h00);

        // R10: still open after cause/unmapped writes, lock then reopen by reset
        bus_wr(2'd1, 8'h21);
        bus_rd(2'd1, rd); chk("R9 write accepted after cause write", rd, 8'h21);
        do_reset(7'b0000010);
        bus_wr(2'd1, 8'h00);
        bus_rd(2'd1, rd); chk("R10 reopened", rd, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule